// File: doc/BRIEF.md
# Protection Lookaside Address Checker

This block checks one memory access per cycle against a table of programmable protection entries and a fixed set of region rules. Each entry gives a base address, a page size of 1 KB, 4 KB, 1 MB or 4 MB, and a set of permission bits. The block compares the access address with every entry at once, applies the read and write permission rules to the entries that hit, and then applies the region rules for the system register space and the top on-chip memory space. The answer is either a pass, an exception with a two-bit code, or a hardware-error flag.

The check itself is combinational, so a core can use the answer in the same cycle that it presents the access. When a valid access faults, two pairs of fault registers capture the address and an encoded status on the next clock edge. A data fault also records the program counter on the instruction side. The entry tables and the table-enable bit come from a register bank outside the block. Caches and exception dispatch are not part of this block.

Top module: `plc_checker`

## Requirements
- R1: An entry takes part only when attribute bit 0 (valid) is set. An entry whose valid bit is clear never hits and never sets its bit in the hit mask.
- R2: An entry hits when base <= address < base + page. The page is selected by attribute bits 17:16: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB. Entry i sets bit i of the hit mask.
- R3: For a write to a hitting entry, a user-mode write needs attribute bit 3 and a supervisor write needs attribute bit 4. Otherwise the result is a violation (code 1).
- R4: A write to a hitting entry whose attribute has bit 12 (L1-cacheable) set while bit 14 (write-through) and bit 7 (dirty) are both clear is a violation.
- R5: A user-mode read of a hitting entry needs attribute bit 2, otherwise it is a violation. Supervisor reads are always permitted.
- R6: The access size is a log2 byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). If the address AND (bytes-1) is nonzero, and there is no entry violation and fewer than two hits, the result is misaligned (code 3).
- R7: With the table enabled, two or more hits always give the multiple-hit result (code 2). This result takes priority over violation, misalignment and the region rules.
- R8: Addresses at or above 0xFFC00000 form the system region. An instruction fetch there is a miss (code 0). A data access there is a violation when it is made in user mode or by the second address generator. A supervisor data access from the first address generator passes.
- R9: In the region 0xFF000000 to 0xFFBFFFFF, an instruction fetch passes only within 0xFFA00000 to 0xFFAFFFFF and is a violation anywhere else. A data access within 0xFFA00000 to 0xFFAFFFFF raises the hardware-error output with no exception. Other data accesses in this region pass.
- R10: With the table-enable input low, the access counts as exactly one hit and only the region rules and the alignment rule apply. Entry contents have no effect.
- R11: With the table enabled, an access that hits no entry and is not covered by a region rule is a miss (code 0).
- R12: The fault status holds bit 19 = miss, bit 18 = second address generator, bit 17 = supervisor, bit 16 = write, and bits 15:0 = hit mask. A data fault loads the data-side address with the access address and the data-side status with this status. It also loads the instruction-side address with the PC and the instruction-side status with only bit 17 = supervisor. An instruction fault loads only the instruction side, with the access address and the status.
- R13: The fault registers reset to zero. They change only on the clock edge that follows a valid access with an exception. A passing access, an invalid cycle or a hardware-error result leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_en | input | 1 | Protection table enable |
| ent_base | input | NENT*32 | Entry base addresses, entry i at bits i*32 +: 32 |
| ent_attr | input | NENT*32 | Entry attribute words, entry i at bits i*32 +: 32 |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | Access size as log2 of bytes |
| acc_write | input | 1 | Access is a write |
| acc_inst | input | 1 | Access is an instruction fetch |
| acc_supv | input | 1 | Access is made in supervisor mode |
| acc_agen2 | input | 1 | Access comes from the second address generator |
| acc_pc | input | 32 | Program counter of the access |
| chk_fault | output | 1 | Exception raised for a valid access |
| chk_code | output | 2 | Exception code: 0 miss, 1 violation, 2 multiple hit, 3 misaligned |
| chk_hwerr | output | 1 | Hardware-error flag for a valid access |
| dfault_addr | output | 32 | Data-side fault address |
| dfault_stat | output | 32 | Data-side fault status |
| ifault_addr | output | 32 | Instruction-side fault address |
| ifault_stat | output | 32 | Instruction-side fault status |

## Verification
The fault, code and hardware-error outputs are due in the same cycle as the access, with no register on the path. The bench drives each access on a falling edge and samples these outputs 1 ns later. The four fault registers are due one rising edge after a valid faulting access. The bench reads them at the next falling edge, after that edge has passed and before any new access can reach them. Scenarios that must leave the registers untouched read them at the same point and compare them with the values from the last fault.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int AW = 32;

  // Attribute bit positions
  localparam int A_VALID = 0;
  localparam int A_UREAD = 2;
  localparam int A_UWRITE = 3;
  localparam int A_SWRITE = 4;
  localparam int A_DIRTY = 7;
  localparam int A_L1C = 12;
  localparam int A_WTHRU = 14;
  localparam int A_PGLO = 16;

  // Region constants
  localparam logic [AW-1:0] SYS_BASE = 32'hFFC0_0000;
  localparam logic [7:0] TOP_TAG = 8'hFF;
  localparam logic [11:0] XWIN_TAG = 12'hFFA;

  // Status bit positions
  localparam int S_MISS = 19;
  localparam int S_AG2 = 18;
  localparam int S_SUPV = 17;
  localparam int S_WR = 16;

  typedef enum logic [1:0] {
    EXC_MISS = 2'd0,
    EXC_VIOL = 2'd1,
    EXC_MULTI = 2'd2,
    EXC_MISAL = 2'd3
  } exc_code_e;

  typedef enum logic [2:0] {
    IMP_NONE,
    IMP_OK,
    IMP_MISS,
    IMP_VIOL,
    IMP_MISAL,
    IMP_HWERR
  } imp_res_e;

  function automatic logic [AW:0] page_bytes(input logic [1:0] sel);
    case (sel)
      2'd0: page_bytes = (AW+1)'(33'h400);
      2'd1: page_bytes = (AW+1)'(33'h1000);
      2'd2: page_bytes = (AW+1)'(33'h10_0000);
      default: page_bytes = (AW+1)'(33'h40_0000);
    endcase
  endfunction
endpackage

// File: rtl/plc_entry.sv
module plc_entry
  import plc_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] attr,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          supv,
  output logic          hit,
  output logic          viol
);
  logic [AW:0] lo, hi, a_ext;
  logic wr_bad, rd_bad, wb_clean;
  logic unused_attr;

  assign unused_attr = ^{attr[AW-1:18], attr[15], attr[13], attr[11:8],
                         attr[6:5], attr[1]};

  always_comb begin
    lo = {1'b0, base};
    hi = lo + page_bytes(attr[A_PGLO+1:A_PGLO]);
    a_ext = {1'b0, addr};
    hit = attr[A_VALID] && (a_ext >= lo) && (a_ext < hi);
    wb_clean = attr[A_L1C] && !attr[A_WTHRU] && !attr[A_DIRTY];
    wr_bad = (!supv && !attr[A_UWRITE]) || (supv && !attr[A_SWRITE]) || wb_clean;
    rd_bad = !supv && !attr[A_UREAD];
    viol = hit && (wr ? wr_bad : rd_bad);
  end

  // R1
  always_comb begin
    valid_gate_chk: assert (attr[A_VALID] || !hit);
  end
endmodule

// File: rtl/plc_implicit.sv
module plc_implicit
  import plc_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          inst,
  input  logic          supv,
  input  logic          agen2,
  output imp_res_e      res
);
  logic [AW-1:0] amask;
  logic misal, in_sys, in_top, in_xwin;

  always_comb begin
    amask = (AW'(1) << size) - AW'(1);
    misal = |(addr & amask);
    in_sys = addr >= SYS_BASE;
    in_top = addr[AW-1:AW-8] == TOP_TAG;
    in_xwin = addr[AW-1:AW-12] == XWIN_TAG;
    if (misal) res = IMP_MISAL;
    else if (in_sys) begin
      if (inst) res = IMP_MISS;
      else if (!supv || agen2) res = IMP_VIOL;
      else res = IMP_OK;
    end else if (in_top) begin
      if (inst) res = in_xwin ? IMP_OK : IMP_VIOL;
      else res = in_xwin ? IMP_HWERR : IMP_OK;
    end else res = IMP_NONE;
  end
endmodule

// File: rtl/plc_fault_log.sv
module plc_fault_log
  import plc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          log_en,
  input  logic          inst,
  input  logic          supv,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] stat,
  output logic [AW-1:0] d_addr,
  output logic [AW-1:0] d_stat,
  output logic [AW-1:0] i_addr,
  output logic [AW-1:0] i_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      d_addr <= '0;
      d_stat <= '0;
      i_addr <= '0;
      i_stat <= '0;
    end else if (log_en) begin
      if (inst) begin
        i_addr <= addr;
        i_stat <= stat;
      end else begin
        d_addr <= addr;
        d_stat <= stat;
        i_addr <= pc;
        i_stat <= AW'({supv, 17'd0});
      end
    end
  end

  // R12
  dlog_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (log_en && !inst) |=> (i_addr == $past(pc) && d_addr == $past(addr)));

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !log_en |=> ($stable(d_addr) && $stable(d_stat) && $stable(i_addr) && $stable(i_stat)));
endmodule

// File: rtl/plc_checker.sv
module plc_checker
  import plc_pkg::*;
#(
  parameter int NENT = 16,
  localparam int CW = $clog2(NENT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_en,
  input  logic [NENT*32-1:0] ent_base,
  input  logic [NENT*32-1:0] ent_attr,
  input  logic               acc_valid,
  input  logic [31:0]        acc_addr,
  input  logic [1:0]         acc_size,
  input  logic               acc_write,
  input  logic               acc_inst,
  input  logic               acc_supv,
  input  logic               acc_agen2,
  input  logic [31:0]        acc_pc,
  output logic               chk_fault,
  output logic [1:0]         chk_code,
  output logic               chk_hwerr,
  output logic [31:0]        dfault_addr,
  output logic [31:0]        dfault_stat,
  output logic [31:0]        ifault_addr,
  output logic [31:0]        ifault_stat
);
  logic [NENT-1:0] hit_vec, viol_vec, mask;
  logic [CW-1:0] hits;
  logic any_viol, exc, hwerr;
  exc_code_e code;
  imp_res_e imp;
  logic [31:0] stat;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    plc_entry u_ent (
      .base (ent_base[i*32 +: 32]),
      .attr (ent_attr[i*32 +: 32]),
      .addr (acc_addr),
      .wr   (acc_write),
      .supv (acc_supv),
      .hit  (hit_vec[i]),
      .viol (viol_vec[i])
    );
  end

  plc_implicit u_imp (
    .addr  (acc_addr),
    .size  (acc_size),
    .inst  (acc_inst),
    .supv  (acc_supv),
    .agen2 (acc_agen2),
    .res   (imp)
  );

  always_comb begin
    mask = tbl_en ? hit_vec : '0;
    hits = tbl_en ? CW'($countones(hit_vec)) : CW'(1);
    any_viol = tbl_en && (|viol_vec);
    exc = 1'b0;
    hwerr = 1'b0;
    code = EXC_MISS;
    if (any_viol || hits >= CW'(2)) begin
      exc = 1'b1;
      code = (hits >= CW'(2)) ? EXC_MULTI : EXC_VIOL;
    end else begin
      case (imp)
        IMP_OK: exc = 1'b0;
        IMP_HWERR: hwerr = 1'b1;
        IMP_MISS: begin exc = 1'b1; code = EXC_MISS; end
        IMP_VIOL: begin exc = 1'b1; code = EXC_VIOL; end
        IMP_MISAL: begin exc = 1'b1; code = EXC_MISAL; end
        default: begin
          exc = (hits != CW'(1));
          code = EXC_MISS;
        end
      endcase
    end
    stat = '0;
    stat[S_MISS] = exc && (code == EXC_MISS);
    stat[S_AG2] = acc_agen2;
    stat[S_SUPV] = acc_supv;
    stat[S_WR] = acc_write;
    stat[NENT-1:0] = mask;
  end

  assign chk_fault = acc_valid && exc;
  assign chk_code = code;
  assign chk_hwerr = acc_valid && hwerr;

  plc_fault_log u_log (
    .clk    (clk),
    .rst    (rst),
    .log_en (chk_fault),
    .inst   (acc_inst),
    .supv   (acc_supv),
    .addr   (acc_addr),
    .pc     (acc_pc),
    .stat   (stat),
    .d_addr (dfault_addr),
    .d_stat (dfault_stat),
    .i_addr (ifault_addr),
    .i_stat (ifault_stat)
  );

  // R7
  multi_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && tbl_en && $countones(hit_vec) > 1) |-> (chk_fault && chk_code == 2'd2));

  // R9
  hwerr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(chk_hwerr && chk_fault));

  // R10
  dis_table_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !tbl_en && acc_addr < 32'hFF00_0000 && acc_size == 2'd0) |-> !chk_fault);
endmodule

// File: tb/tb_plc_checker.sv
`timescale 1ns/1ps
module tb_plc_checker;
  localparam int NENT = 16;
  localparam logic [31:0] V = 32'h1, UR = 32'h4, UW = 32'h8, SW = 32'h10;
  localparam logic [31:0] DT = 32'h80, L1 = 32'h1000, WT = 32'h4000;

  logic clk = 1'b0, rst = 1'b1, tbl_en = 1'b0;
  logic [NENT*32-1:0] ent_base = '0, ent_attr = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_inst = 1'b0, acc_supv = 1'b0, acc_agen2 = 1'b0;
  logic [31:0] acc_addr = '0, acc_pc = '0;
  logic [1:0] acc_size = '0;
  logic chk_fault, chk_hwerr;
  logic [1:0] chk_code;
  logic [31:0] dfault_addr, dfault_stat, ifault_addr, ifault_stat;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  plc_checker #(.NENT(NENT)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_tbl();
    ent_base = '0;
    ent_attr = '0;
  endtask

  task automatic set_ent(input int i, input logic [31:0] b, input logic [31:0] a);
    ent_base[i*32 +: 32] = b;
    ent_attr[i*32 +: 32] = a;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                     input logic ins, input logic sv, input logic ag, input logic [31:0] pc);
    @(negedge clk);
    acc_addr = a; acc_size = sz; acc_write = wr; acc_inst = ins;
    acc_supv = sv; acc_agen2 = ag; acc_pc = pc; acc_valid = 1'b1;
    #1;
  endtask

  task automatic done_acc();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic f, input logic [1:0] c, input logic h);
    chk({req, " fault"}, 32'(chk_fault), 32'(f));
    if (f) chk({req, " code"}, 32'(chk_code), 32'(c));
    chk({req, " hwerr"}, 32'(chk_hwerr), 32'(h));
  endtask

  task automatic t_reset();
    chk("R13 reset daddr", dfault_addr, 0);
    chk("R13 reset dstat", dfault_stat, 0);
    chk("R13 reset iaddr", ifault_addr, 0);
    chk("R13 reset istat", ifault_stat, 0);
  endtask

  task automatic t_r1();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h1000, UR);
    acc(32'h1000, 2, 0, 0, 0, 0, 0); expect_res("R1 invalid entry miss", 1, 0, 0); done_acc();
    chk("R1 mask empty", dfault_stat, 32'h0008_0000);
    set_ent(0, 32'h1000, UR | V);
    acc(32'h1000, 2, 0, 0, 0, 0, 0); expect_res("R1 valid entry pass", 0, 0, 0); done_acc();
  endtask

  task automatic t_r2();
    logic [31:0] pg [4] = '{32'h400, 32'h1000, 32'h10_0000, 32'h40_0000};
    clear_tbl(); tbl_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      set_ent(3, 32'h0100_0000, V | UR | (32'(s) << 16));
      acc(32'h0100_0000 + pg[s] - 4, 2, 0, 0, 0, 0, 0); expect_res("R2 last word", 0, 0, 0); done_acc();
      acc(32'h0100_0000 + pg[s], 2, 0, 0, 0, 0, 0); expect_res("R2 past end", 1, 0, 0); done_acc();
      acc(32'h00FF_FFFC, 2, 0, 0, 0, 0, 0); expect_res("R2 below base", 1, 0, 0); done_acc();
    end
  endtask

  task automatic t_r3();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h2000, V | UR | UW);
    acc(32'h2000, 2, 1, 0, 0, 0, 0); expect_res("R3 user write ok", 0, 0, 0); done_acc();
    acc(32'h2000, 2, 1, 0, 1, 0, 0); expect_res("R3 supv write no SW", 1, 1, 0); done_acc();
    set_ent(0, 32'h2000, V | SW);
    acc(32'h2000, 2, 1, 0, 0, 0, 0); expect_res("R3 user write no UW", 1, 1, 0); done_acc();
    acc(32'h2000, 2, 1, 0, 1, 0, 0); expect_res("R3 supv write ok", 0, 0, 0); done_acc();
  endtask

  task automatic t_r4();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h2000, V | UW | SW | L1);
    acc(32'h2000, 2, 1, 0, 1, 0, 0); expect_res("R4 clean wb write", 1, 1, 0); done_acc();
    set_ent(0, 32'h2000, V | UW | SW | L1 | DT);
    acc(32'h2000, 2, 1, 0, 1, 0, 0); expect_res("R4 dirty ok", 0, 0, 0); done_acc();
    set_ent(0, 32'h2000, V | UW | SW | L1 | WT);
    acc(32'h2000, 2, 1, 0, 1, 0, 0); expect_res("R4 write-through ok", 0, 0, 0); done_acc();
  endtask

  task automatic t_r5();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h2000, V);
    acc(32'h2000, 2, 0, 0, 0, 0, 0); expect_res("R5 user read no UR", 1, 1, 0); done_acc();
    acc(32'h2000, 2, 0, 0, 1, 0, 0); expect_res("R5 supv read", 0, 0, 0); done_acc();
  endtask

  task automatic t_r6();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h2000, V | UR);
    acc(32'h2002, 2, 0, 0, 0, 0, 0); expect_res("R6 misaligned word", 1, 3, 0); done_acc();
    acc(32'h2002, 1, 0, 0, 0, 0, 0); expect_res("R6 aligned half", 0, 0, 0); done_acc();
    set_ent(0, 32'h2000, V);
    acc(32'h2002, 2, 0, 0, 0, 0, 0); expect_res("R6 violation wins", 1, 1, 0); done_acc();
  endtask

  task automatic t_r7();
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'h3000, V | UR);
    set_ent(1, 32'h3000, V | UR | (32'd1 << 16));
    acc(32'h3001, 2, 0, 0, 0, 0, 0); expect_res("R7 multiple hit", 1, 2, 0); done_acc();
    chk("R7 status mask", dfault_stat, 32'h0000_0003);
  endtask

  task automatic t_r8();
    clear_tbl(); tbl_en = 1'b0;
    acc(32'hFFC0_0000, 2, 0, 1, 1, 0, 0); expect_res("R8 fetch sys", 1, 0, 0); done_acc();
    acc(32'hFFC0_0100, 2, 0, 0, 0, 0, 0); expect_res("R8 user data sys", 1, 1, 0); done_acc();
    acc(32'hFFC0_0100, 2, 0, 0, 1, 1, 0); expect_res("R8 agen2 sys", 1, 1, 0); done_acc();
    acc(32'hFFC0_0100, 2, 1, 0, 1, 0, 0); expect_res("R8 supv data sys", 0, 0, 0); done_acc();
  endtask

  task automatic t_r9();
    logic [31:0] ia, is_;
    clear_tbl(); tbl_en = 1'b0;
    acc(32'hFFA0_0010, 2, 0, 1, 0, 0, 0); expect_res("R9 fetch window", 0, 0, 0); done_acc();
    acc(32'hFF80_0000, 2, 0, 1, 0, 0, 0); expect_res("R9 fetch outside", 1, 1, 0); done_acc();
    ia = ifault_addr; is_ = ifault_stat;
    acc(32'hFFA0_0000, 2, 0, 0, 1, 0, 0); expect_res("R9 data window hwerr", 0, 0, 1); done_acc();
    chk("R13 hwerr no log", ifault_addr, ia);
    chk("R13 hwerr no log stat", ifault_stat, is_);
    acc(32'hFF80_0000, 2, 1, 0, 0, 0, 0); expect_res("R9 data top ok", 0, 0, 0); done_acc();
  endtask

  task automatic t_r10();
    clear_tbl(); tbl_en = 1'b0;
    set_ent(0, 32'h4000, V);
    set_ent(1, 32'h4000, V);
    acc(32'h4000, 2, 1, 0, 0, 0, 0); expect_res("R10 disabled ignores table", 0, 0, 0); done_acc();
    acc(32'h4001, 2, 0, 0, 0, 0, 0); expect_res("R10 disabled misalign", 1, 3, 0); done_acc();
  endtask

  task automatic t_r11();
    clear_tbl(); tbl_en = 1'b1;
    acc(32'h5000, 2, 0, 0, 0, 0, 0); expect_res("R11 no hit miss", 1, 0, 0); done_acc();
  endtask

  task automatic t_r12();
    logic [31:0] da, ds;
    clear_tbl(); tbl_en = 1'b1;
    acc(32'h6000, 2, 1, 0, 0, 1, 32'h0000_1234); expect_res("R12 data miss", 1, 0, 0); done_acc();
    chk("R12 daddr", dfault_addr, 32'h6000);
    chk("R12 dstat", dfault_stat, 32'h000D_0000);
    chk("R12 iaddr pc", ifault_addr, 32'h0000_1234);
    chk("R12 istat user", ifault_stat, 32'h0);
    set_ent(5, 32'h7000, V | UR);
    acc(32'h7000, 2, 1, 0, 1, 0, 32'h0000_5678); expect_res("R12 supv viol", 1, 1, 0); done_acc();
    chk("R12 dstat viol", dfault_stat, 32'h0003_0020);
    chk("R12 iaddr pc2", ifault_addr, 32'h0000_5678);
    chk("R12 istat supv", ifault_stat, 32'h0002_0000);
    da = dfault_addr; ds = dfault_stat;
    acc(32'h8000, 2, 0, 1, 1, 0, 32'h9999); expect_res("R12 fetch miss", 1, 0, 0); done_acc();
    chk("R12 inst iaddr", ifault_addr, 32'h8000);
    chk("R12 inst istat", ifault_stat, 32'h000A_0000);
    chk("R12 inst keeps daddr", dfault_addr, da);
    chk("R12 inst keeps dstat", dfault_stat, ds);
  endtask

  task automatic t_r13();
    logic [31:0] da, ia;
    clear_tbl(); tbl_en = 1'b1;
    set_ent(0, 32'hA000, V | UR);
    da = dfault_addr; ia = ifault_addr;
    acc(32'hA000, 2, 0, 0, 0, 0, 32'h1111); expect_res("R13 pass", 0, 0, 0); done_acc();
    chk("R13 pass no log d", dfault_addr, da);
    chk("R13 pass no log i", ifault_addr, ia);
    @(negedge clk);
    acc_addr = 32'hB000; acc_write = 1'b1; acc_valid = 1'b0;
    @(negedge clk);
    chk("R13 invalid no log", dfault_addr, da);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_r1(); t_r2(); t_r3(); t_r4(); t_r5(); t_r6(); t_r7();
    t_r8(); t_r9(); t_r10(); t_r11(); t_r12(); t_r13();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule